// File: doc/BRIEF.md
# Unaligned Vector Load-Right Unit

This unit executes the trailing half of a 128-bit vector load whose address does not fall on a 16-byte boundary. It takes an instruction word in either of two accepted encodings, together with the two 64-bit general-register read values that the issue stage has already fetched. It forms the byte address and fetches the 16-byte line that holds it through a request/response memory port. It then writes a vector register with the selected bytes packed against the high-numbered lanes and zeros in every other lane.

The four low address bits set the byte count n. The line's first n bytes land in the top n lanes, in address order. When n is zero the result is all zeros, so the unit skips the memory read and writes the zero vector at once. Each instruction produces exactly one outcome, announced by a one-cycle pulse: either a register write or an illegal-instruction flag. The unit accepts a new instruction only when the previous one has finished.

Top module: `vld_right_unit`

## Requirements
- R1: After reset, in_ready is 1 and wr_en, illegal and mem_req_valid are 0.
- R2: The byte address is ea = base + in_opb (modulo 2^64).
  - base is 0 when the 5-bit address-register field insn[20:16] is zero, and in_opa otherwise.
  - The read request carries ea with its four low bits cleared.
- R3: Let n = ea[3:0]. Byte lane k occupies wr_data[127-8k -: 8], and line byte j (line address + j) arrives in mem_rsp_data[127-8j -: 8].
  - Lanes 16-n .. 15 receive line bytes 0 .. n-1 in order.
  - Lanes 0 .. 15-n are zero.
- R4: When n = 0 and the word is legal, no memory request is made. wr_en pulses on the cycle after acceptance, with wr_data all zeros.
- R5: Format A is legal when insn[31:26] = 31 and insn[10:1] is 551 or 807. Its destination index is insn[25:21], zero-extended to 7 bits. insn[0] is ignored.
- R6: Format B is legal when all three hold:
  - insn[31:26] = 4;
  - insn[10:4] is 68 or 100;
  - insn[1:0] = 2'b11.

  Its destination index is {insn[3:2], insn[25:21]}.
- R7: The hint opcodes (807 in format A, 100 in format B) produce the same write as the plain opcodes.
- R8: A word that matches neither format raises illegal for exactly one cycle, on the cycle after acceptance. It issues no memory request and produces no write.
- R9: Each accepted instruction produces exactly one single-cycle pulse, either wr_en or illegal. in_ready stays low from acceptance until that pulse has been seen.
- R10: Once raised, mem_req_valid and mem_req_addr hold steady until the cycle in which mem_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 64 | Value of the address-base register |
| in_opb | input | 64 | Value of the offset register |
| mem_req_valid | output | 1 | Line read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | 16-byte-aligned line address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 128 | Line bytes, lowest address in the top byte |
| wr_en | output | 1 | Vector register write pulse |
| wr_idx | output | 7 | Destination vector register index |
| wr_data | output | 128 | Vector written |
| illegal | output | 1 | Unrecognised instruction pulse |

## Verification
Byte offsets of 1, 15 and intermediate values are run against a memory whose byte values depend on their address. A wrong shift amount or a reversed lane order therefore shows up as a wrong byte, not just as a misplaced zero. Offset zero is exercised in both formats to separate the skipped-read path from an off-by-one shift. A zero address-register field paired with a non-zero operand value, and an address sum that wraps past 2^64, exercise the base selection and the adder. Destination indices with both high bits set, hint opcodes and near-miss words (a wrong extended opcode, or the wrong format-B tail) separate the two decoders from each other. A long back-to-back run with varying memory stall and latency checks the handshakes.

// File: rtl/vldr_pkg.sv
package vldr_pkg;

   // Control sequence of one instruction
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } vldr_state_e;

   localparam logic [5:0] OPC_FMT_A  = 6'd31;
   localparam logic [5:0] OPC_FMT_B  = 6'd4;
   localparam logic [1:0] TAIL_FMT_B = 2'b11;

endpackage

// File: rtl/vldr_decode.sv
module vldr_decode #(
   parameter int unsigned VIDX_W    = 7,
   parameter int unsigned XO_A      = 551,
   parameter int unsigned XO_A_HINT = 807,
   parameter int unsigned XO_B      = 68,
   parameter int unsigned XO_B_HINT = 100
) (
   input  logic [31:0]       insn,
   output logic              legal,
   output logic [VIDX_W-1:0] vidx,
   output logic              base_is_zero
);
   import vldr_pkg::*;

   if (VIDX_W < 7) begin : g_bad_vidx
      $error("vldr_decode: VIDX_W must hold the 7-bit split index");
   end
   if (XO_A >= 1024 || XO_A_HINT >= 1024) begin : g_bad_xoa
      $error("vldr_decode: format A opcode needs more than 10 bits");
   end
   if (XO_B >= 128 || XO_B_HINT >= 128) begin : g_bad_xob
      $error("vldr_decode: format B opcode needs more than 7 bits");
   end

   logic [5:0] f_opc;
   logic [9:0] f_xo_a;
   logic [6:0] f_xo_b;
   logic [1:0] f_tail_b;
   logic [4:0] f_dst_lo;
   logic [1:0] f_dst_hi;
   logic [4:0] f_base;
   logic       hit_a;
   logic       hit_b;
   logic       unused_fields;

   assign f_opc    = insn[31:26];
   assign f_dst_lo = insn[25:21];
   assign f_base   = insn[20:16];
   assign f_xo_a   = insn[10:1];
   assign f_xo_b   = insn[10:4];
   assign f_dst_hi = insn[3:2];
   assign f_tail_b = insn[1:0];
   // The offset-register field only names a register already read upstream
   assign unused_fields = ^insn[15:11];

   always_comb begin
      hit_a = (f_opc == OPC_FMT_A) &&
              ((f_xo_a == 10'(XO_A)) || (f_xo_a == 10'(XO_A_HINT)));
      hit_b = (f_opc == OPC_FMT_B) && (f_tail_b == TAIL_FMT_B) &&
              ((f_xo_b == 7'(XO_B)) || (f_xo_b == 7'(XO_B_HINT)));
      legal = hit_a || hit_b;
      if (hit_b) begin
         vidx = VIDX_W'({f_dst_hi, f_dst_lo});
      end else begin
         vidx = VIDX_W'(f_dst_lo);
      end
      base_is_zero = (f_base == 5'd0);
   end

endmodule

// File: rtl/vldr_agen.sv
module vldr_agen #(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned LINE_BYTES = 16
) (
   input  logic                          base_is_zero,
   input  logic [XLEN-1:0]               opa,
   input  logic [XLEN-1:0]               opb,
   output logic [XLEN-1:0]               line_addr,
   output logic [$clog2(LINE_BYTES)-1:0] fill
);
   localparam int unsigned OFS_W = $clog2(LINE_BYTES);

   if ((1 << OFS_W) != LINE_BYTES || LINE_BYTES < 2) begin : g_bad_line
      $error("vldr_agen: LINE_BYTES must be a power of two, at least 2");
   end
   if (XLEN <= OFS_W) begin : g_bad_xlen
      $error("vldr_agen: XLEN too small for the line offset");
   end

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] ea;

   always_comb begin
      base      = base_is_zero ? '0 : opa;
      ea        = base + opb;
      line_addr = {ea[XLEN-1:OFS_W], {OFS_W{1'b0}}};
      fill      = ea[OFS_W-1:0];
   end

endmodule

// File: rtl/vldr_lane_merge.sv
module vldr_lane_merge #(
   parameter int unsigned LINE_BYTES = 16,
   parameter int unsigned STYLE      = 0   // 0: one barrel shift, 1: per-lane mux
) (
   input  logic [8*LINE_BYTES-1:0]       line,
   input  logic [$clog2(LINE_BYTES)-1:0] fill,
   output logic [8*LINE_BYTES-1:0]       vec
);
   localparam int unsigned DATA_W = 8 * LINE_BYTES;
   localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
   localparam int unsigned SH_W   = $clog2(DATA_W) + 1;

   if (STYLE > 1) begin : g_bad_style
      $error("vldr_lane_merge: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_shift
      logic [SH_W-1:0] shamt;
      always_comb begin
         shamt = SH_W'((LINE_BYTES - int'(fill)) * 8);
         vec   = (fill == '0) ? '0 : (line >> shamt);
      end
   end else begin : g_mux
      logic [7:0] src_byte [LINE_BYTES];
      for (genvar j = 0; j < LINE_BYTES; j++) begin : g_src
         assign src_byte[j] = line[DATA_W-1-8*j -: 8];
      end
      for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
         logic [OFS_W-1:0] pick;
         logic             take;
         // lane k holds line byte k + fill - LINE_BYTES, i.e. (k + fill) mod LINE_BYTES
         assign pick = OFS_W'(k) + fill;
         assign take = (int'(fill) + k) >= int'(LINE_BYTES);
         assign vec[DATA_W-1-8*k -: 8] = take ? src_byte[pick] : 8'h00;
      end
   end

endmodule

// File: rtl/vld_right_unit.sv
module vld_right_unit #(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned LINE_BYTES  = 16,
   parameter int unsigned VIDX_W      = 7,
   parameter int unsigned MERGE_STYLE = 0,
   parameter int unsigned XO_A        = 551,
   parameter int unsigned XO_A_HINT   = 807,
   parameter int unsigned XO_B        = 68,
   parameter int unsigned XO_B_HINT   = 100
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [31:0]             in_insn,
   input  logic [XLEN-1:0]         in_opa,
   input  logic [XLEN-1:0]         in_opb,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [XLEN-1:0]         mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [8*LINE_BYTES-1:0] mem_rsp_data,
   output logic                    wr_en,
   output logic [VIDX_W-1:0]       wr_idx,
   output logic [8*LINE_BYTES-1:0] wr_data,
   output logic                    illegal
);
   import vldr_pkg::*;

   localparam int unsigned DATA_W = 8 * LINE_BYTES;
   localparam int unsigned OFS_W  = $clog2(LINE_BYTES);

   logic              dec_legal;
   logic [VIDX_W-1:0] dec_vidx;
   logic              dec_base_zero;
   logic [XLEN-1:0]   ag_line;
   logic [OFS_W-1:0]  ag_fill;
   logic [DATA_W-1:0] merged;

   vldr_state_e       state_q;
   logic [XLEN-1:0]   addr_q;
   logic [OFS_W-1:0]  fill_q;
   logic [VIDX_W-1:0] vidx_q;
   logic              bad_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   vldr_decode #(
      .VIDX_W(VIDX_W), .XO_A(XO_A), .XO_A_HINT(XO_A_HINT),
      .XO_B(XO_B), .XO_B_HINT(XO_B_HINT)
   ) u_dec (
      .insn(in_insn), .legal(dec_legal), .vidx(dec_vidx),
      .base_is_zero(dec_base_zero)
   );

   vldr_agen #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_agen (
      .base_is_zero(dec_base_zero), .opa(in_opa), .opb(in_opb),
      .line_addr(ag_line), .fill(ag_fill)
   );

   vldr_lane_merge #(.LINE_BYTES(LINE_BYTES), .STYLE(MERGE_STYLE)) u_merge (
      .line(mem_rsp_data), .fill(fill_q), .vec(merged)
   );

   assign accept = in_valid && (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         fill_q  <= '0;
         vidx_q  <= '0;
         bad_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (in_valid) begin
                  vidx_q <= dec_vidx;
                  bad_q  <= !dec_legal;
                  fill_q <= ag_fill;
                  addr_q <= ag_line;
                  data_q <= '0;
                  if (dec_legal && (ag_fill != '0)) begin
                     state_q <= ST_REQ;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  data_q  <= merged;
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready      = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign wr_en         = (state_q == ST_DONE) && !bad_q;
   assign illegal       = (state_q == ST_DONE) && bad_q;
   assign wr_idx        = vidx_q;
   assign wr_data       = data_q;

   // ---------------- assertions ----------------
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
      else $error("request dropped or changed before acceptance");

   p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[OFS_W-1:0] == '0))
      else $error("misaligned line request");

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !in_ready)
      else $error("accepting while a read is outstanding");

   p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || illegal) |=> !(wr_en || illegal))
      else $error("completion pulse longer than one cycle");

   p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && illegal))
      else $error("write and illegal together");

   p_zero_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dec_legal && (ag_fill == '0)) |=>
         (wr_en && (wr_data == '0) && !mem_req_valid))
      else $error("zero-offset load did not complete at once");

   p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !dec_legal) |=> (illegal && !wr_en && !mem_req_valid))
      else $error("bad word not flagged");

endmodule

// File: tb/sim_vld_right_unit.sv
module sim_vld_right_unit;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         in_ready;
   logic [31:0]  in_insn;
   logic [63:0]  in_opa;
   logic [63:0]  in_opb;
   logic         mem_req_valid;
   logic         mem_req_ready;
   logic [63:0]  mem_req_addr;
   logic         mem_rsp_valid;
   logic [127:0] mem_rsp_data;
   logic         wr_en;
   logic [6:0]   wr_idx;
   logic [127:0] wr_data;
   logic         illegal;

   int n_run  = 0;
   int n_fail = 0;

   // expected outcome queues (reference model)
   bit           q_bad  [$];
   logic [6:0]   q_idx  [$];
   logic [127:0] q_data [$];
   logic [63:0]  q_addr [$];

   always #5 clk = ~clk;

   vld_right_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
      .in_opa(in_opa), .in_opb(in_opb),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input logic [63:0] a);
      return 8'(a * 64'd29) ^ a[15:8] ^ a[31:24] ^ 8'h3C;
   endfunction

   function automatic logic [127:0] mline(input logic [63:0] a);
      logic [127:0] d;
      for (int j = 0; j < 16; j++) d[127-8*j -: 8] = mbyte(a + 64'(j));
      return d;
   endfunction

   function automatic logic [31:0] enc_a(input int xo, input logic [4:0] vd,
                                         input logic [4:0] ra, input logic [4:0] rb);
      return {6'd31, vd, ra, rb, 10'(xo), 1'b0};
   endfunction

   function automatic logic [31:0] enc_b(input int xo, input logic [6:0] vd,
                                         input logic [4:0] ra, input logic [4:0] rb);
      return {6'd4, vd[4:0], ra, rb, 7'(xo), vd[6:5], 2'b11};
   endfunction

   // Reference model: decode and result from the requirement text
   task automatic model(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
      bit ok_a, ok_b;
      logic [6:0]   idx;
      logic [63:0]  ea;
      int           n;
      logic [127:0] d;
      ok_a = (w[31:26] == 6'd31) && (w[10:1] == 10'd551 || w[10:1] == 10'd807);
      ok_b = (w[31:26] == 6'd4) && (w[10:4] == 7'd68 || w[10:4] == 7'd100) &&
             (w[1:0] == 2'b11);
      idx  = ok_b ? {w[3:2], w[25:21]} : {2'b00, w[25:21]};
      ea   = ((w[20:16] == 5'd0) ? 64'd0 : a) + b;
      n    = int'(ea[3:0]);
      d    = '0;
      if (!(ok_a || ok_b)) begin
         q_bad.push_back(1'b1); q_idx.push_back(idx); q_data.push_back('0);
      end else begin
         for (int k = 0; k < 16; k++)
            if (k >= 16 - n) d[127-8*k -: 8] = mbyte({ea[63:4], 4'h0} + 64'(k - 16 + n));
         q_bad.push_back(1'b0); q_idx.push_back(idx); q_data.push_back(d);
         if (n != 0) q_addr.push_back({ea[63:4], 4'h0});
      end
   endtask

   task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      in_valid = 1'b1; in_insn = w; in_opa = a; in_opb = b;
      while (!in_ready) @(negedge clk);
      model(w, a, b);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Memory responder with varying stall and latency
   initial begin
      int  tick = 0;
      bit  hs_prev = 0;
      bit  busy = 0;
      int  lat = 0;
      logic [63:0] a_prev = '0;
      logic [63:0] a_hold = '0;
      logic [63:0] ea_exp;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         tick++;
         mem_rsp_valid = 1'b0;
         if (hs_prev) begin
            if (q_addr.size() == 0) begin
               chk(1'b0, "R4", "unexpected memory request", 128'(a_prev), '0);
            end else begin
               ea_exp = q_addr.pop_front();
               chk(a_prev == ea_exp, "R2", "line address", 128'(a_prev), 128'(ea_exp));
            end
            busy = 1; lat = tick % 4; a_hold = a_prev;
         end
         if (busy) begin
            if (lat == 0) begin
               mem_rsp_valid = 1'b1; mem_rsp_data = mline(a_hold); busy = 0;
            end else begin
               lat--;
            end
         end
         mem_req_ready = mem_req_valid && (tick % 3 != 1);
         hs_prev = mem_req_valid && mem_req_ready;
         a_prev  = mem_req_addr;
      end
   end

   // Every-cycle comparison of completions against the model
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1) begin
            if (mem_req_valid && in_ready)
               chk(1'b0, "R9", "ready while read outstanding", 1, 0);
            if (wr_en || illegal) begin
               if (q_bad.size() == 0) begin
                  chk(1'b0, "R9", "completion without instruction", 128'(wr_idx), '0);
               end else begin
                  bit b; logic [6:0] i; logic [127:0] d;
                  b = q_bad.pop_front(); i = q_idx.pop_front(); d = q_data.pop_front();
                  chk(illegal == b, "R8", "illegal flag", 128'(illegal), 128'(b));
                  chk(wr_en == !b, "R9", "write pulse", 128'(wr_en), 128'(!b));
                  if (!b) begin
                     chk(wr_idx == i, "R5/R6 (R5 R6)", "destination", 128'(wr_idx), 128'(i));
                     chk(wr_data == d, "R3", "vector data", wr_data, d);
                  end
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_opa = '0; in_opb = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(in_ready == 1'b1, "R1", "in_ready", 128'(in_ready), 1);
      chk(wr_en == 1'b0, "R1", "wr_en", 128'(wr_en), 0);
      chk(illegal == 1'b0, "R1", "illegal", 128'(illegal), 0);
      chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 128'(mem_req_valid), 0);
      rst_n = 1'b1;

      issue(enc_a(551, 5'd9, 5'd3, 5'd4), 64'h1000, 64'h5);              // R3 n=5
      issue(enc_a(551, 5'd31, 5'd1, 5'd2), 64'h2000_0000_0000_00F0, 64'hF); // R3 n=15
      issue(enc_a(551, 5'd0, 5'd7, 5'd8), 64'h3000, 64'h1);              // R3 n=1
      issue(enc_a(551, 5'd4, 5'd2, 5'd3), 64'h4000, 64'h20);             // R4 n=0
      issue(enc_a(551, 5'd6, 5'd0, 5'd5), 64'hDEAD_BEEF_0000_0000, 64'h5037); // R2 base zero
      issue(enc_a(807, 5'd12, 5'd3, 5'd4), 64'h6000, 64'h9);             // R7 hint A
      issue(enc_b(68, 7'd101, 5'd3, 5'd4), 64'h7000, 64'hC);             // R6 split index
      issue(enc_b(100, 7'd64, 5'd0, 5'd2), 64'hFFFF, 64'h8003);          // R7 hint B
      issue(enc_b(68, 7'd33, 5'd1, 5'd1), 64'h9000, 64'h0);              // R4 format B
      issue(enc_a(552, 5'd1, 5'd1, 5'd1), 64'h10, 64'h1);                // R8 near miss
      issue(enc_b(68, 7'd5, 5'd1, 5'd1) & 32'hFFFF_FFFC, 64'h10, 64'h1); // R8 tail
      issue(32'h0, 64'h0, 64'h3);                                        // R8 zero word
      issue(enc_a(551, 5'd2, 5'd1, 5'd1) | 32'h1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10); // R2 wrap
      for (int i = 0; i < 40; i++) begin
         if (i % 2 == 0)
            issue(enc_a((i % 4 == 0) ? 551 : 807, 5'(i), 5'(i % 3), 5'd1),
                  64'(i) * 64'h1_0001_0003, 64'(i * 7));
         else
            issue(enc_b((i % 3 == 0) ? 100 : 68, 7'(i * 3), 5'(i % 5), 5'd2),
                  64'(i) * 64'h2_0000_0011, 64'(i * 5));
      end

      repeat (40) @(negedge clk);
      chk(q_bad.size() == 0, "R9", "outcomes pending", 128'(q_bad.size()), 0);
      chk(q_addr.size() == 0, "R2", "requests pending", 128'(q_addr.size()), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule